// File: doc/BRIEF.md
# Power-Good Fault Latch and Logger

This block watches a rail-good signal that is already synchronous to its clock and keeps two kinds of report strictly apart. The present-good output shows what the rail is doing right now. The fault output only remembers that the rail went bad at some point. Next to these two outputs the block keeps a small set of diagnostic records. It counts outages, stores the longest outage and the most recent one, and stamps each event with a relative time.

There is no real-time clock. Time is measured by a saturating tick counter that starts from zero at reset, one tick per clock. The boot index of the current power cycle comes in on an input and is copied into the record at each event. A monotonic event number makes the order of records unambiguous.

Software reads the records through a small address/data port. It is told about new outages through an interrupt line instead of by polling. A single clear strobe acknowledges the interrupt and drops the fault flag.

Top module: `pg_fault_logger`

## Requirements
- R1: `pg_o` equals `rail_ok_i` in the same cycle, combinationally, with no storage.
- R2: `fault_o` rises one clock after the rail goes from good to bad. It stays high, even after the rail recovers, until `clr_i` is sampled high. If a new outage start and `clr_i` fall in the same cycle, `fault_o` is set. The rail is treated as good at reset, so an outage ends only the way it began, on an edge.
- R3: `irq_o` follows the same rules as `fault_o`. It is set by an outage start and cleared by `clr_i`, and the set wins when both happen in the same cycle.
- R4: The outage count (read address 0) rises by one on each good-to-bad edge and holds at its all-ones value.
- R5: The length of an outage is the number of clock cycles during which `rail_ok_i` was low. It is stored at read address 2 on the bad-to-good edge, and it holds at the all-ones value of its width.
- R6: Read address 1 holds the largest outage length stored so far.
- R7: Read address 3 holds the tick value at the most recent event, where an event is either an outage start or an outage end. The tick is the number of clock cycles since reset was released, and it holds at its all-ones value.
- R8: Read address 4 holds `boot_idx_i` as it was sampled at the most recent event. Changes to `boot_idx_i` between events do not alter it.
- R9: Read address 5 holds an event number that rises by one on every outage start and every outage end, and holds at its all-ones value.
- R10: Read address 6 returns {`irq_o`, `fault_o`, `pg_o`} in bits 2..0. Address 7 reads zero. After reset all stored values, `fault_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_ok_i | input | 1 | Synchronised rail-good level |
| boot_idx_i | input | BOOT_W | Boot index of the current power cycle |
| clr_i | input | 1 | Clears the fault flag and the interrupt |
| rd_addr_i | input | 3 | Record select |
| pg_o | output | 1 | Present-good |
| fault_o | output | 1 | Sticky past-bad flag |
| irq_o | output | 1 | New-outage interrupt |
| rd_data_o | output | RD_W | Selected record, zero-extended |

## Verification
Two things can land on the same clock edge: the clear strobe and a new outage start. The bench provokes this by dropping the rail and raising `clr_i` on the same edge. Both `fault_o` and `irq_o` must then read high, because the new outage must not be lost. The opposite case is checked too: a clear given while the rail is still bad must leave both flags low until the next falling edge. The other records are checked against a cycle-counted model in the bench, over a sweep of outage lengths and run past every saturation point of a narrowed configuration.

// File: rtl/pg_fault_logger.sv
module pg_fault_logger #(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 8,
  parameter int DUR_W  = 12,
  parameter int BOOT_W = 8,
  parameter int EID_W  = 8,
  parameter int RD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rail_ok_i,
  input  logic [BOOT_W-1:0] boot_idx_i,
  input  logic              clr_i,
  input  logic [2:0]        rd_addr_i,
  output logic              pg_o,
  output logic              fault_o,
  output logic              irq_o,
  output logic [RD_W-1:0]   rd_data_o
);

  logic              rail_q;
  logic [TICK_W-1:0] tick_q, ts_q;
  logic [CNT_W-1:0]  out_cnt_q;
  logic [DUR_W-1:0]  cur_dur_q, last_dur_q, max_dur_q;
  logic [BOOT_W-1:0] boot_q;
  logic [EID_W-1:0]  eid_q;
  logic              fault_q, irq_q;

  wire fall  = rail_q & ~rail_ok_i;
  wire rise  = ~rail_q & rail_ok_i;
  wire hold  = ~rail_q & ~rail_ok_i;
  wire event_w = fall | rise;

  assign pg_o    = rail_ok_i;
  assign fault_o = fault_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_q     <= 1'b1;
      tick_q     <= '0;
      ts_q       <= '0;
      out_cnt_q  <= '0;
      cur_dur_q  <= '0;
      last_dur_q <= '0;
      max_dur_q  <= '0;
      boot_q     <= '0;
      eid_q      <= '0;
      fault_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      rail_q <= rail_ok_i;
      tick_q <= tick_q + TICK_W'(~&tick_q);
      if (fall) begin
        fault_q   <= 1'b1;
        irq_q     <= 1'b1;
        out_cnt_q <= out_cnt_q + CNT_W'(~&out_cnt_q);
        cur_dur_q <= DUR_W'(1);
      end else begin
        if (clr_i) begin
          fault_q <= 1'b0;
          irq_q   <= 1'b0;
        end
        if (hold)
          cur_dur_q <= cur_dur_q + DUR_W'(~&cur_dur_q);
      end
      if (rise) begin
        last_dur_q <= cur_dur_q;
        if (cur_dur_q > max_dur_q)
          max_dur_q <= cur_dur_q;
      end
      if (event_w) begin
        ts_q   <= tick_q;
        boot_q <= boot_idx_i;
        eid_q  <= eid_q + EID_W'(~&eid_q);
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      3'd0:    rd_data_o = RD_W'(out_cnt_q);
      3'd1:    rd_data_o = RD_W'(max_dur_q);
      3'd2:    rd_data_o = RD_W'(last_dur_q);
      3'd3:    rd_data_o = RD_W'(ts_q);
      3'd4:    rd_data_o = RD_W'(boot_q);
      3'd5:    rd_data_o = RD_W'(eid_q);
      3'd6:    rd_data_o = RD_W'({irq_q, fault_q, rail_ok_i});
      default: rd_data_o = '0;
    endcase
  end

endmodule

module pg_fault_logger_chk #(
  parameter int CNT_W = 8,
  parameter int DUR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rail_ok_i,
  input logic             clr_i,
  input logic             fault_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] out_cnt,
  input logic [DUR_W-1:0] max_dur,
  input logic [DUR_W-1:0] last_dur
);

  // R2
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && !clr_i |=> fault_o);

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !$past(rail_ok_i));

  // R4
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> (out_cnt != $past(out_cnt)) || (&out_cnt));

  // R6
  max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_dur >= last_dur);

  // R2
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o) |-> $past(clr_i) && !irq_o);

endmodule

bind pg_fault_logger pg_fault_logger_chk #(.CNT_W(CNT_W), .DUR_W(DUR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rail_ok_i(rail_ok_i), .clr_i(clr_i),
  .fault_o(fault_o), .irq_o(irq_o), .out_cnt(out_cnt_q),
  .max_dur(max_dur_q), .last_dur(last_dur_q)
);

// File: tb/pg_fault_logger_tb.sv
module pg_fault_logger_tb_top;
  localparam int TW = 10, CW = 4, DW = 6, BW = 4, EW = 5, RW = 32;
  localparam int TMAX = (1 << TW) - 1, CMAX = (1 << CW) - 1;
  localparam int DMAX = (1 << DW) - 1, EMAX = (1 << EW) - 1;

  logic clk = 0, rst_n = 0, rail = 1, clr = 0;
  logic [BW-1:0] boot = '0;
  logic [2:0] addr = '0;
  logic pg, fault, irq;
  logic [RW-1:0] rdata;
  int total = 0, bad = 0, ncyc = 0;
  int e_cnt = 0, e_max = 0, e_last = 0, e_ts = 0, e_boot = 0, e_eid = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  pg_fault_logger #(.TICK_W(TW), .CNT_W(CW), .DUR_W(DW), .BOOT_W(BW),
    .EID_W(EW), .RD_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rail_ok_i(rail), .boot_idx_i(boot),
    .clr_i(clr), .rd_addr_i(addr), .pg_o(pg), .fault_o(fault),
    .irq_o(irq), .rd_data_o(rdata));

  function automatic int sat(int v, int m); return (v > m) ? m : v; endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, string tag, int exp);
    addr = a; #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic check_all();
    rd(3'd0, "R4 count", e_cnt);
    rd(3'd1, "R6 max", e_max);
    rd(3'd2, "R5 last", e_last);
    rd(3'd3, "R7 stamp", e_ts);
    rd(3'd4, "R8 boot", e_boot);
    rd(3'd5, "R9 event id", e_eid);
  endtask

  task automatic mark_event();
    e_ts = sat(ncyc, TMAX);
    e_boot = int'(boot);
    e_eid = sat(e_eid + 1, EMAX);
  endtask

  task automatic outage(int len);
    @(negedge clk);
    rail = 0; #1;
    chk("R1 pg low", int'(pg), 0);
    mark_event();
    e_cnt = sat(e_cnt + 1, CMAX);
    repeat (len) @(negedge clk);
    rail = 1; #1;
    chk("R1 pg high", int'(pg), 1);
    mark_event();
    e_last = sat(len, DMAX);
    if (e_last > e_max) e_max = e_last;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset fault", int'(fault), 0);
    chk("R10 reset irq", int'(irq), 0);
    check_all();
    rd(3'd6, "R10 status", 1);
    rd(3'd7, "R10 unused", 0);

    for (int len = 1; len <= 12; len++) begin
      boot = BW'(len);
      outage(len);
      chk("R2 fault latched", int'(fault), 1);
      chk("R3 irq set", int'(irq), 1);
      rd(3'd6, "R10 status", 7);
      boot = BW'(len + 5);
      check_all();
      repeat (len % 3) @(negedge clk);
      do_clear();
      chk("R2 fault cleared", int'(fault), 0);
      chk("R3 irq cleared", int'(irq), 0);
    end

    outage(3);
    do_clear();
    outage(70);
    check_all();
    do_clear();

    @(negedge clk);
    rail = 0; clr = 1;
    mark_event(); e_cnt = sat(e_cnt + 1, CMAX);
    @(negedge clk);
    clr = 0;
    chk("R2 clear vs start", int'(fault), 1);
    chk("R3 clear vs start", int'(irq), 1);
    do_clear();
    chk("R2 clear while bad", int'(fault), 0);
    chk("R3 clear while bad", int'(irq), 0);
    repeat (4) @(negedge clk);
    chk("R2 stays clear", int'(fault), 0);
    rail = 1;
    mark_event();
    e_last = sat(7, DMAX);
    @(negedge clk);
    check_all();

    for (int k = 0; k < 20; k++) outage(1);
    check_all();
    do_clear();

    repeat (1100) @(negedge clk);
    outage(2);
    check_all();
    boot = ~boot;
    repeat (2) @(negedge clk);
    rd(3'd4, "R8 boot held", e_boot);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule